// File: doc/BRIEF.md
# Multi-Block Transfer Sequencer

This block keeps the byte and block bookkeeping for a memory-card data transfer. It takes a programmed block length in bytes and a programmed block count. On a start strobe it copies both values. It then counts the per-byte strobes arriving from the data path. When the last byte of a block arrives it marks the end of that block, and it closes the transfer either after the programmed number of blocks or when a stop-command strobe arrives. Serialization, CRC work and command issue belong to neighbouring blocks.

There are two transfer modes. In counted mode the block count is nonzero and the transfer finishes on its own after exactly that many blocks. In endless mode the block count is zero and blocks keep coming until a stop-command strobe ends the transfer. A stop strobe ends a transfer in either mode. A block length of zero is refused: the start is rejected and an error flag is raised instead.

All four outputs are registered, so each reacts one clock after the input strobe that causes it.

Top module: `msq_xfer_seq`

## Requirements
- R1: After reset is released, `blk_end_o`, `xfer_done_o`, `busy_o` and `len_err_o` are all 0.
- R2: A start strobe while idle with `blk_len_i` equal to 0 sets `len_err_o` in the next cycle and leaves `busy_o` at 0. The flag stays set until a later start is accepted.
- R3: A start strobe while idle with a nonzero `blk_len_i` raises `busy_o` in the next cycle and clears `len_err_o`. Length and count are sampled at that start, so changes to `blk_len_i` and `blk_cnt_i` during the transfer have no effect on it.
- R4: While busy, the byte strobe that completes a block (the `blk_len_i`-th strobe since the block began) makes `blk_end_o` high for exactly the next cycle. The byte count then restarts at zero for the next block.
- R5: In counted mode (`blk_cnt_i` from 1 to 2^CNT_W-1, 1 to 65535 at the default width), `xfer_done_o` pulses for one cycle in the same cycle as the final `blk_end_o`, and `busy_o` is 0 in that same cycle.
- R6: In endless mode (`blk_cnt_i` equal to 0), the transfer never finishes on its own. `xfer_done_o` stays 0 and `busy_o` stays 1 until a stop strobe.
- R7: A stop strobe while busy, in either mode, drops `busy_o` and pulses `xfer_done_o` in the next cycle. A byte strobe in the same cycle as the stop is discarded and produces no `blk_end_o`.
- R8: A stop strobe or byte strobe while idle has no effect on any output. A start strobe while busy is ignored, even one with a zero length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_len_i | input | LEN_W | Programmed bytes per block; 0 is refused |
| blk_cnt_i | input | CNT_W | Programmed blocks per transfer; 0 selects endless mode |
| start_i | input | 1 | One-cycle strobe that begins a transfer |
| byte_i | input | 1 | One-cycle strobe, one per byte moved by the data path |
| stop_i | input | 1 | One-cycle strobe for a stop-transmission command |
| blk_end_o | output | 1 | One-cycle pulse after the byte that completes a block |
| xfer_done_o | output | 1 | One-cycle pulse when the transfer ends |
| busy_o | output | 1 | High while a transfer is in progress |
| len_err_o | output | 1 | Set by a start refused for zero length |

## Verification
The bench builds the block with LEN_W = 4 and CNT_W = 4 rather than the defaults of 12 and 16. With these widths the largest legal length (15 bytes) and the largest block count (15 blocks) both fit within a few hundred cycles. This makes the counter wrap points and the full-count transfer directly testable. Smaller cases are also exercised: one-byte blocks, a single-block transfer, endless mode ended by stop, a stop that coincides with the final byte, and input changes made in the middle of a transfer.

// File: rtl/msq_pkg.sv
package msq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       err;
        logic       blk_end;
        logic       done;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{st: SEQ_IDLE, err: 1'b0, blk_end: 1'b0, done: 1'b0};

endpackage

// File: rtl/msq_byte_ctr.sv
module msq_byte_ctr #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             inc_i,
    input  logic             drop_i,
    output logic             wrap_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
    } byte_state_t;

    byte_state_t st_d, st_q;
    logic        at_last;

    assign at_last = (st_q.cnt == (st_q.len - LEN_W'(1)));
    assign wrap_o  = inc_i && at_last;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.len = len_i;
            st_d.cnt = '0;
        end else if (drop_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/msq_blk_ctr.sv
module msq_blk_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             inc_i,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] done;
    } blk_state_t;

    blk_state_t st_d, st_q;
    logic       endless;

    assign endless = (st_q.total == '0);
    assign last_o  = !endless && (st_q.done == (st_q.total - CNT_W'(1)));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.total = total_i;
            st_d.done  = '0;
        end else if (inc_i && !endless) begin
            st_d.done = st_q.done + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/msq_ctrl.sv
module msq_ctrl
    import msq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic byte_i,
    input  logic stop_i,
    input  logic len_zero_i,
    input  logic wrap_i,
    input  logic last_i,
    output logic load_o,
    output logic inc_byte_o,
    output logic inc_blk_o,
    output logic drop_o,
    output logic busy_o,
    output logic err_o,
    output logic blk_end_o,
    output logic done_o
);
    ctrl_state_t st_d, st_q;
    logic        running;

    assign running    = (st_q.st == SEQ_RUN);
    assign load_o     = !running && start_i && !len_zero_i;
    assign inc_byte_o = running && byte_i && !stop_i;
    assign inc_blk_o  = wrap_i;
    assign drop_o     = running && stop_i;

    always_comb begin
        st_d         = st_q;
        st_d.blk_end = 1'b0;
        st_d.done    = 1'b0;
        if (!running) begin
            if (start_i) begin
                if (len_zero_i) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.err = 1'b0;
                    st_d.st  = SEQ_RUN;
                end
            end
        end else if (stop_i) begin
            st_d.st   = SEQ_IDLE;
            st_d.done = 1'b1;
        end else if (wrap_i) begin
            st_d.blk_end = 1'b1;
            if (last_i) begin
                st_d.st   = SEQ_IDLE;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = running;
    assign err_o     = st_q.err;
    assign blk_end_o = st_q.blk_end;
    assign done_o    = st_q.done;
endmodule

// File: rtl/msq_xfer_seq.sv
module msq_xfer_seq #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] blk_len_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             start_i,
    input  logic             byte_i,
    input  logic             stop_i,
    output logic             blk_end_o,
    output logic             xfer_done_o,
    output logic             busy_o,
    output logic             len_err_o
);
    logic load, inc_byte, inc_blk, drop, wrap, last_blk, len_zero;

    assign len_zero = (blk_len_i == '0);

    msq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_i     (byte_i),
        .stop_i     (stop_i),
        .len_zero_i (len_zero),
        .wrap_i     (wrap),
        .last_i     (last_blk),
        .load_o     (load),
        .inc_byte_o (inc_byte),
        .inc_blk_o  (inc_blk),
        .drop_o     (drop),
        .busy_o     (busy_o),
        .err_o      (len_err_o),
        .blk_end_o  (blk_end_o),
        .done_o     (xfer_done_o)
    );

    msq_byte_ctr #(.LEN_W(LEN_W)) u_bytes (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .len_i  (blk_len_i),
        .inc_i  (inc_byte),
        .drop_i (drop),
        .wrap_o (wrap)
    );

    msq_blk_ctr #(.CNT_W(CNT_W)) u_blocks (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .total_i (blk_cnt_i),
        .inc_i   (inc_blk),
        .last_o  (last_blk)
    );
endmodule

// File: rtl/msq_xfer_seq_chk.sv
module msq_xfer_seq_chk #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] blk_len_i,
    input logic [CNT_W-1:0] blk_cnt_i,
    input logic             start_i,
    input logic             byte_i,
    input logic             stop_i,
    input logic             blk_end_o,
    input logic             xfer_done_o,
    input logic             busy_o,
    input logic             len_err_o
);
    logic endless_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            endless_q <= 1'b0;
        end else if (!busy_o && start_i && blk_len_i != '0) begin
            endless_q <= (blk_cnt_i == '0);
        end
    end

    a_r2_zero_len_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && blk_len_i == '0) |=> (!busy_o && len_err_o));

    a_r3_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && blk_len_i != '0) |=> (busy_o && !len_err_o));

    a_r4_end_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_i |=> !blk_end_o);

    a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |-> !busy_o);

    a_r6_endless_no_self_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && endless_q && !stop_i) |=> (busy_o && !xfer_done_o));

    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |=> (!busy_o && xfer_done_o && !blk_end_o));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !blk_end_o && !xfer_done_o && $stable(len_err_o)));
endmodule

bind msq_xfer_seq msq_xfer_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_len_i   (blk_len_i),
    .blk_cnt_i   (blk_cnt_i),
    .start_i     (start_i),
    .byte_i      (byte_i),
    .stop_i      (stop_i),
    .blk_end_o   (blk_end_o),
    .xfer_done_o (xfer_done_o),
    .busy_o      (busy_o),
    .len_err_o   (len_err_o)
);

// File: tb/tb_msq_xfer_seq.sv
`timescale 1ns/1ps
module tb_msq_xfer_seq;
    localparam int LEN_W = 4;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [CNT_W-1:0] blk_cnt = '0;
    logic             start = 1'b0, byte_s = 1'b0, stop = 1'b0;
    logic             blk_end, xfer_done, busy, len_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    msq_xfer_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_len_i   (blk_len),
        .blk_cnt_i   (blk_cnt),
        .start_i     (start),
        .byte_i      (byte_s),
        .stop_i      (stop),
        .blk_end_o   (blk_end),
        .xfer_done_o (xfer_done),
        .busy_o      (busy),
        .len_err_o   (len_err)
    );

    // One clock: drive strobes, let the edge pass, compare all outputs.
    task automatic cyc(input logic st, input logic by, input logic sp,
                       input logic e_end, input logic e_done, input logic e_busy,
                       input logic e_err, input string req);
        start = st; byte_s = by; stop = sp;
        @(posedge clk);
        #1;
        n_checks++;
        if ({blk_end, xfer_done, busy, len_err} !== {e_end, e_done, e_busy, e_err}) begin
            n_fail++;
            $display("FAIL %s: end/done/busy/err actual %b%b%b%b expected %b%b%b%b", req,
                     blk_end, xfer_done, busy, len_err, e_end, e_done, e_busy, e_err);
        end
        @(negedge clk);
        start = 1'b0; byte_s = 1'b0; stop = 1'b0;
    endtask

    task automatic run_blocks(input int len, input int nblk, input bit counted, input string req);
        for (int b = 0; b < nblk; b++) begin
            for (int i = 0; i < len; i++) begin
                automatic bit e_end = (i == len - 1);
                automatic bit fin   = counted && e_end && (b == nblk - 1);
                cyc(0, 1, 0, e_end, fin, !fin, 0, req);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    endtask

    task automatic t_zero_len();
        blk_len = 0; blk_cnt = 2;
        cyc(1, 0, 0, 0, 0, 0, 1, "R2");
        cyc(0, 1, 0, 0, 0, 0, 1, "R2");
        cyc(0, 0, 0, 0, 0, 0, 1, "R2");
        blk_len = 2; blk_cnt = 1;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        run_blocks(2, 1, 1, "R5");
    endtask

    task automatic t_counted();
        blk_len = 3; blk_cnt = 2;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 0, 0, 0, 0, 1, 0, "R4");
        run_blocks(3, 2, 1, "R4");
        cyc(0, 0, 0, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_one_byte();
        blk_len = 1; blk_cnt = 3;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        run_blocks(1, 3, 1, "R4");
    endtask

    task automatic t_max();
        blk_len = 15; blk_cnt = 15;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        run_blocks(15, 15, 1, "R5");
    endtask

    task automatic t_endless();
        blk_len = 2; blk_cnt = 0;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        run_blocks(2, 20, 0, "R6");
        cyc(0, 1, 0, 0, 0, 1, 0, "R6");
        cyc(0, 0, 1, 0, 1, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    endtask

    task automatic t_stop_on_last();
        blk_len = 2; blk_cnt = 1;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 1, 0, 0, 0, 1, 0, "R7");
        cyc(0, 1, 1, 0, 1, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, "R7");
        // byte count was discarded: a fresh transfer needs the full length
        blk_len = 3; blk_cnt = 1;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        run_blocks(3, 1, 1, "R7");
    endtask

    task automatic t_idle_and_busy_ignores();
        cyc(0, 0, 1, 0, 0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 0, 0, "R8");
        blk_len = 2; blk_cnt = 2;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 1, 0, 0, 0, 1, 0, "R8");
        blk_len = 0;
        cyc(1, 0, 0, 0, 0, 1, 0, "R8");
        blk_len = 2;
        cyc(1, 1, 0, 1, 0, 1, 0, "R8");
        run_blocks(2, 1, 1, "R8");
    endtask

    task automatic t_mid_change();
        blk_len = 2; blk_cnt = 2;
        cyc(1, 0, 0, 0, 0, 1, 0, "R3");
        blk_len = 5; blk_cnt = 7;
        run_blocks(2, 2, 1, "R3");
    endtask

    initial begin
        t_reset();
        t_zero_len();
        t_counted();
        t_one_byte();
        t_max();
        t_endless();
        t_stop_on_last();
        t_idle_and_busy_ignores();
        t_mid_change();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule